// File: doc/BRIEF.md
# GPIO Register Bank with Function Select and Latched Outputs

This block is a word-addressed control register file for 54 general-purpose pins. Each pin has a 3-bit function code. The codes are packed ten to a 32-bit select word, in six words. Each pin also has a latched level bit, and the level bits are split into a 32-pin bank and a 22-pin bank. Write-only set and clear registers change the level latch. Four pull-control words hold plain read/write storage and come out of reset with fixed patterns.

On the pin side, the block gives one registered drive bit per pin. It also gives the function codes of pins 48 to 53 to an external multiplexer. The drive bit does not simply mirror the level latch:

- A set or clear write always updates the latch.
- The drive bit moves only when the pin's code selects output and the latched level really changes.
- Changing a code on its own never changes a drive bit.

The bus is a single-cycle port. A request is taken on a rising edge. Read data and an error pulse appear on the following cycle.

Top module: `gpio_regbank`

## Requirements
- R1: Reset state. After reset:
  - all function codes and both level latches are zero;
  - pin_out is zero, and rsp_rdata and rsp_err are zero;
  - the pull words at word addresses 57, 58, 59 and 60 read 0xAAA95555, 0xA0AAAAAA, 0x50AAA95A and 0x00055555.
- R2: Function-select layout.
  - Word address k (0 to 5) holds pin 10*k+i in bits [3i+2:3i], and a written value reads back.
  - Bits 31:30 read zero.
  - Fields for pins above 53 read zero and ignore writes.
- R3: A set write ORs the write data into a level bank. Word 7 covers pins 0-31. Word 8 covers pins 32-53 in bits 21:0.
- R4: A clear write removes the written bits from a level bank. Word 10 covers pins 0-31. Word 11 covers pins 32-53 in bits 21:0.
- R5: Drive bit rules. pin_out reflects each rule on the cycle after the write.
  - A pin's drive bit goes high on a set write only when its code is 1 (output) and its level was 0.
  - It goes low on a clear write only when its code is 1 and its level was 1.
  - In every other case it holds, including when only the code changes.
- R6: The level words at word addresses 13 and 14 return the latches. Bits 31:22 of word 14 read zero. Writes to both words are ignored.
- R7: The set and clear words read zero. Reserved word addresses 16 to 35 read zero, ignore writes and raise no error.
- R8: The pull words at word addresses 57 to 60 are fully read/write.
- R9: Read data is valid on the cycle after a read request. rsp_rdata is zero on any cycle that does not follow a read.
- R10: An unmapped word address reads zero and a write to it changes nothing. rsp_err is high for exactly the cycle after such a request.
- R11: mux_fsel carries the codes of pins 48 to 53, with pin 48 in bits 2:0 and each later pin three bits higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, cycle after a read |
| rsp_err | output | 1 | One-cycle pulse after an unmapped access |
| pin_out | output | 54 | Registered per-pin drive value |
| mux_fsel | output | 18 | Function codes of pins 48..53 |

## Verification
Random streams mix three kinds of select writes:
- random select data, which leaves few pins in output mode;
- all-output patterns, in which set and clear move the drive bits;
- writes that mix the two, so the level latch and the drive bits drift apart.

Directed sequences force that drift on pin 0. A level is set while the pin is an input, then the pin is switched to output, then the pin is set and cleared again. This separates a design that copies the latch to the pin from one that follows the change-only rule. Writes to level words, reserved words, unmapped words and the fields above pin 53 are each followed by read-backs, which show that nothing changed.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int FSEL_W   = 3;
    localparam int NUM_PULL = 4;

    // word addresses of the register map
    localparam int A_SET_BASE  = 7;
    localparam int A_CLR_BASE  = 10;
    localparam int A_LEV_BASE  = 13;
    localparam int A_RSVD_LO   = 16;
    localparam int A_RSVD_HI   = 35;
    localparam int A_PULL_BASE = 57;

    typedef enum logic [FSEL_W-1:0] {
        FN_INPUT  = 3'd0,
        FN_OUTPUT = 3'd1,
        FN_ALT5   = 3'd2,
        FN_ALT4   = 3'd3,
        FN_ALT0   = 3'd4,
        FN_ALT1   = 3'd5,
        FN_ALT2   = 3'd6,
        FN_ALT3   = 3'd7
    } fn_code_e;

    localparam logic [NUM_PULL-1:0][DATA_W-1:0] PULL_RESET = {
        32'h0005_5555, 32'h50AA_A95A, 32'hA0AA_AAAA, 32'hAAA9_5555
    };

    typedef struct packed {
        logic       fsel;
        logic       set;
        logic       clr;
        logic       lev;
        logic       rsvd;
        logic       pull;
        logic       unmapped;
        logic [2:0] idx;
    } dec_t;

endpackage

// File: rtl/gpio_fsel_store.sv
module gpio_fsel_store #(
    parameter int NUM_PINS  = 54,
    parameter int FSEL_W    = 3,
    parameter int PER_WORD  = 10,
    parameter int DATA_W    = 32,
    localparam int NUM_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD,
    localparam int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [IDX_W-1:0]                      widx,
    input  logic [DATA_W-1:0]                     wdata,
    output logic [NUM_PINS-1:0][FSEL_W-1:0]       codes,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]      rd_words,
    output logic [NUM_PINS-1:0]                   is_out
);

    typedef struct packed {
        logic [NUM_PINS-1:0][FSEL_W-1:0] code;
    } fsel_st_t;

    fsel_st_t st_d, st_q;

    localparam logic [FSEL_W-1:0] OUT_CODE = FSEL_W'(1);

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (we && (p / PER_WORD) == int'(widx)) begin
                st_d.code[p] = wdata[(p % PER_WORD) * FSEL_W +: FSEL_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_words = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            for (int i = 0; i < PER_WORD; i++) begin
                if (w * PER_WORD + i < NUM_PINS) begin
                    rd_words[w][i * FSEL_W +: FSEL_W] = st_q.code[w * PER_WORD + i];
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            is_out[p] = (st_q.code[p] == OUT_CODE);
        end
    end

    assign codes = st_q.code;

endmodule

// File: rtl/gpio_level_bank.sv
module gpio_level_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] is_out,
    output logic [W-1:0] lev,
    output logic [W-1:0] drive
);

    typedef struct packed {
        logic [W-1:0] lev;
        logic [W-1:0] drv;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.drv = st_q.drv | (wdata & ~st_q.lev & is_out);
            st_d.lev = st_q.lev | wdata;
        end else if (clr_we) begin
            st_d.drv = st_q.drv & ~(wdata & st_q.lev & is_out);
            st_d.lev = st_q.lev & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lev   = st_q.lev;
    assign drive = st_q.drv;

endmodule

// File: rtl/gpio_pull_regs.sv
module gpio_pull_regs #(
    parameter int NUM    = 4,
    parameter int DATA_W = 32,
    parameter logic [NUM-1:0][DATA_W-1:0] RESET_VAL = '0,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NUM-1:0][DATA_W-1:0]  words
);

    typedef struct packed {
        logic [NUM-1:0][DATA_W-1:0] w;
    } pull_st_t;

    pull_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (we && int'(widx) == i) st_d.w[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_VAL;
        else        st_q <= st_d;
    end

    assign words = st_q.w;

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int PER_WORD  = 10,
    parameter int MUX_FIRST = 48,
    parameter int MUX_CNT   = 6,
    localparam int NUM_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD,
    localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W,
    localparam int SEL_IDX_W = $clog2(NUM_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic                        rsp_err,
    output logic [NUM_PINS-1:0]         pin_out,
    output logic [MUX_CNT*FSEL_W-1:0]   mux_fsel
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_st_t;

    rsp_st_t rsp_d, rsp_q;
    dec_t    dec;

    logic [NUM_PINS-1:0][FSEL_W-1:0]   codes;
    logic [NUM_WORDS-1:0][DATA_W-1:0]  fsel_words;
    logic [NUM_PINS-1:0]               is_out;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  lev_words;
    logic [NUM_PULL-1:0][DATA_W-1:0]   pull_words;

    // address decode
    always_comb begin
        int a;
        a   = int'(req_addr);
        dec = '0;
        if (a < NUM_WORDS) begin
            dec.fsel = 1'b1;
            dec.idx  = 3'(a);
        end else if (a >= A_SET_BASE && a < A_SET_BASE + NUM_BANKS) begin
            dec.set = 1'b1;
            dec.idx = 3'(a - A_SET_BASE);
        end else if (a >= A_CLR_BASE && a < A_CLR_BASE + NUM_BANKS) begin
            dec.clr = 1'b1;
            dec.idx = 3'(a - A_CLR_BASE);
        end else if (a >= A_LEV_BASE && a < A_LEV_BASE + NUM_BANKS) begin
            dec.lev = 1'b1;
            dec.idx = 3'(a - A_LEV_BASE);
        end else if (a >= A_RSVD_LO && a <= A_RSVD_HI) begin
            dec.rsvd = 1'b1;
        end else if (a >= A_PULL_BASE && a < A_PULL_BASE + NUM_PULL) begin
            dec.pull = 1'b1;
            dec.idx  = 3'(a - A_PULL_BASE);
        end else begin
            dec.unmapped = 1'b1;
        end
    end

    gpio_fsel_store #(
        .NUM_PINS (NUM_PINS),
        .FSEL_W   (FSEL_W),
        .PER_WORD (PER_WORD),
        .DATA_W   (DATA_W)
    ) fsel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (req_valid && req_write && dec.fsel),
        .widx     (dec.idx[SEL_IDX_W-1:0]),
        .wdata    (req_wdata),
        .codes    (codes),
        .rd_words (fsel_words),
        .is_out   (is_out)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * DATA_W;
        localparam int W  = (NUM_PINS - LO > DATA_W) ? DATA_W : NUM_PINS - LO;

        logic [W-1:0] lev_b;
        logic [W-1:0] drv_b;

        gpio_level_bank #(.W(W)) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (req_valid && req_write && dec.set && int'(dec.idx) == b),
            .clr_we (req_valid && req_write && dec.clr && int'(dec.idx) == b),
            .wdata  (req_wdata[W-1:0]),
            .is_out (is_out[LO +: W]),
            .lev    (lev_b),
            .drive  (drv_b)
        );

        assign lev_words[b]   = DATA_W'(lev_b);
        assign pin_out[LO +: W] = drv_b;
    end

    gpio_pull_regs #(
        .NUM       (NUM_PULL),
        .DATA_W    (DATA_W),
        .RESET_VAL (PULL_RESET)
    ) pull_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (req_valid && req_write && dec.pull),
        .widx  (dec.idx[$clog2(NUM_PULL)-1:0]),
        .wdata (req_wdata),
        .words (pull_words)
    );

    // response path
    always_comb begin
        rsp_d = '0;
        if (req_valid && !req_write) begin
            if (dec.fsel)      rsp_d.rdata = fsel_words[dec.idx[SEL_IDX_W-1:0]];
            else if (dec.lev)  rsp_d.rdata = lev_words[int'(dec.idx)];
            else if (dec.pull) rsp_d.rdata = pull_words[int'(dec.idx)];
        end
        rsp_d.err = req_valid && dec.unmapped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_rdata = rsp_q.rdata;
    assign rsp_err   = rsp_q.err;
    assign mux_fsel  = codes[MUX_FIRST +: MUX_CNT];

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
    import gpio_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic [53:0]       pin_out,
    input logic [17:0]       mux_fsel
);

    logic wr_drive_reg;
    logic rd_sel_word;
    assign wr_drive_reg = req_valid && req_write &&
                          (req_addr == 6'd7 || req_addr == 6'd8 ||
                           req_addr == 6'd10 || req_addr == 6'd11);
    assign rd_sel_word  = req_valid && !req_write && req_addr < 6'd6;

    // pin drive changes only after a set or clear write
    assert_pin_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out != $past(pin_out)) |-> $past(wr_drive_reg));

    // mux codes change only after writes to select words 4 or 5
    assert_mux_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_fsel != $past(mux_fsel)) |->
        $past(req_valid && req_write && (req_addr == 6'd4 || req_addr == 6'd5)));

    // error pulse follows a request
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(req_valid));

    // non-zero data only after a read
    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata != '0) |-> $past(req_valid && !req_write));

    // upper level bits of the second bank read zero
    assert_lev_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && req_addr == 6'd14) |-> rsp_rdata[31:22] == 10'd0);

    // select words have bits 31:30 clear
    assert_sel_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_sel_word) |-> rsp_rdata[31:30] == 2'd0);

endmodule

bind gpio_regbank gpio_regbank_chk chk_i (.*);

// File: tb/gpio_regbank_tb_top.sv
module gpio_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [53:0] pin_out;
    logic [17:0] mux_fsel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [2:0]  m_fsel [54];
    logic [53:0] m_lev;
    logic [53:0] m_out;
    logic [31:0] m_pull [4];

    always #2.5 clk = ~clk;

    gpio_regbank dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .rsp_rdata, .rsp_err, .pin_out, .mux_fsel
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_unmapped(input int a);
        return !(a < 6 || a == 7 || a == 8 || a == 10 || a == 11 || a == 13 || a == 14 ||
                 (a >= 16 && a <= 35) || (a >= 57 && a <= 60));
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] v = '0;
        if (a < 6) begin
            for (int i = 0; i < 10; i++)
                if (a * 10 + i < 54) v[i*3 +: 3] = m_fsel[a*10+i];
        end else if (a == 13) v = m_lev[31:0];
        else if (a == 14) v = {10'd0, m_lev[53:32]};
        else if (a >= 57 && a <= 60) v = m_pull[a-57];
        return v;
    endfunction

    function automatic void model_write(input int a, input logic [31:0] d);
        if (a < 6) begin
            for (int i = 0; i < 10; i++)
                if (a * 10 + i < 54) m_fsel[a*10+i] = d[i*3 +: 3];
        end else if (a == 7 || a == 8 || a == 10 || a == 11) begin
            int base = (a == 8 || a == 11) ? 32 : 0;
            int cnt  = (base == 32) ? 22 : 32;
            for (int i = 0; i < cnt; i++) begin
                int p = base + i;
                if (d[i]) begin
                    if (a == 7 || a == 8) begin
                        if (!m_lev[p] && m_fsel[p] == 3'd1) m_out[p] = 1'b1;
                        m_lev[p] = 1'b1;
                    end else begin
                        if (m_lev[p] && m_fsel[p] == 3'd1) m_out[p] = 1'b0;
                        m_lev[p] = 1'b0;
                    end
                end
            end
        end else if (a >= 57 && a <= 60) m_pull[a-57] = d;
    endfunction

    function automatic logic [17:0] exp_mux();
        logic [17:0] v;
        for (int i = 0; i < 6; i++) v[i*3 +: 3] = m_fsel[48+i];
        return v;
    endfunction

    // one bus operation, then compare every output against the model
    task automatic do_op(input bit wr, input int a, input logic [31:0] d, input string tag);
        logic [31:0] er;
        bit          ee;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 6'(a); req_wdata = d;
        er = wr ? 32'd0 : exp_read(a);
        ee = is_unmapped(a);
        if (wr) model_write(a, d);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(rsp_rdata == er, {tag, " rdata"}, 64'(rsp_rdata), 64'(er));
        check(rsp_err == ee, {tag, " R10 err"}, 64'(rsp_err), 64'(ee));
        check(pin_out == m_out, {tag, " R5 pin_out"}, 64'(pin_out), 64'(m_out));
        check(mux_fsel == exp_mux(), {tag, " R11 mux"}, 64'(mux_fsel), 64'(exp_mux()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < 54; p++) m_fsel[p] = 3'd0;
        m_lev = '0; m_out = '0;
        m_pull[0] = 32'hAAA95555; m_pull[1] = 32'hA0AAAAAA;
        m_pull[2] = 32'h50AAA95A; m_pull[3] = 32'h00055555;

        repeat (3) @(negedge clk);
        // R1: outputs in reset
        check(pin_out == '0, "R1 pin_out in reset", 64'(pin_out), 0);
        check(rsp_rdata == '0 && !rsp_err, "R1 rsp in reset", 64'(rsp_rdata), 0);
        rst_n = 1'b1;

        // R1 / R8: reset contents
        for (int a = 57; a <= 60; a++) do_op(1'b0, a, 0, "R1 pull reset");
        for (int a = 0; a < 6; a++) do_op(1'b0, a, 0, "R1 fsel reset");
        do_op(1'b0, 13, 0, "R1 lev0 reset");
        do_op(1'b0, 14, 0, "R1 lev1 reset");

        // R2: fields above pin 53 and bits 31:30
        do_op(1'b1, 5, 32'hFFFF_FFFF, "R2 write word5");
        do_op(1'b0, 5, 0, "R2 read word5");
        do_op(1'b1, 5, 32'h0000_0000, "R2 clear word5");

        // R5: drive diverges from level on pin 0
        do_op(1'b1, 7, 32'h1, "R3 set input pin");
        do_op(1'b1, 0, 32'h1, "R5 code change only");
        do_op(1'b1, 7, 32'h1, "R5 set while already high");
        do_op(1'b1, 10, 32'h1, "R4 clear output pin");
        do_op(1'b1, 7, 32'h1, "R5 set output pin");
        check(pin_out[0] == 1'b1, "R5 pin0 high", 64'(pin_out[0]), 1);
        do_op(1'b1, 0, 32'h0, "R5 back to input");
        do_op(1'b1, 10, 32'h1, "R5 clear input pin");
        check(pin_out[0] == 1'b1, "R5 pin0 held", 64'(pin_out[0]), 1);
        do_op(1'b0, 13, 0, "R6 lev0 after clear");

        // R6: level words ignore writes; bank 1 upper bits
        do_op(1'b1, 8, 32'hFFFF_FFFF, "R3 set bank1 all");
        do_op(1'b1, 14, 32'h0, "R6 write lev1");
        do_op(1'b1, 13, 32'hFFFF_FFFF, "R6 write lev0");
        do_op(1'b0, 14, 0, "R6 read lev1");
        do_op(1'b0, 13, 0, "R6 read lev0");

        // R7: write-only and reserved words
        do_op(1'b0, 7, 0, "R7 read set");
        do_op(1'b0, 11, 0, "R7 read clr");
        do_op(1'b1, 20, 32'hDEAD_BEEF, "R7 write rsvd");
        do_op(1'b0, 20, 0, "R7 read rsvd");

        // R10: unmapped
        do_op(1'b1, 6, 32'h0924_9249, "R10 write gap");
        do_op(1'b0, 0, 0, "R10 fsel untouched");
        do_op(1'b0, 63, 0, "R10 read unmapped");

        // R8 / R11
        do_op(1'b1, 59, 32'h1234_5678, "R8 pull write");
        do_op(1'b0, 59, 0, "R8 pull read");
        do_op(1'b1, 4, 32'h3FFF_FFFF, "R11 word4");
        do_op(1'b1, 5, 32'h0000_0FAC, "R11 word5");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int kind = $urandom_range(0, 9);
            int a;
            logic [31:0] d = $urandom();
            bit wr = 1'b1;
            case (kind)
                0, 1, 2: begin
                    a = $urandom_range(0, 5);
                    if ($urandom_range(0, 1) == 0) d = 32'h0924_9249;
                end
                3: a = 7 + $urandom_range(0, 1);
                4: a = 10 + $urandom_range(0, 1);
                5: begin a = 13 + $urandom_range(0, 1); wr = $urandom_range(0, 1) == 0; end
                6: a = 57 + $urandom_range(0, 3);
                7: a = $urandom_range(0, 63);
                8: a = $urandom_range(16, 35);
                default: begin a = $urandom_range(0, 63); wr = 1'b0; end
            endcase
            do_op(wr, a, d, "R3 R4 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule